// File: doc/BRIEF.md
# Direct Access Command Sequencer

This block carries out single commands against a one-time-programmable word array on behalf of software. Software loads a byte address and up to two 32-bit data words through a small configuration write port. It then writes a command word that starts a read, a program or a digest-slot program. The sequencer drives a request/response memory port. It returns read data in two registered output words and ends every command with a one-cycle done pulse and a 3-bit result code.

The address space is split into equal partitions selected by the top address bits. Each partition has a fixed access granule of either 32 or 64 bits, chosen by a parameter mask. The address is forced onto that granule. A program operation first reads the target and refuses to clear any bit that is already set. Partitions can be write-locked through an input and read-locked through sticky software bits. While a command runs, the configuration registers are frozen and a write-enable output stays low.

Top module: `direct_access_seq`

## Requirements
- R1: The command word uses bit 0 for read, bit 1 for program and bit 2 for digest. When several bits are set, only the lowest-numbered command runs; for example, value 7 performs a read and leaves the array unchanged.
- R2: The address register is 11 bits. On the memory port, bits 1:0 are forced to zero for a 32-bit access and bits 2:0 for a 64-bit access.
- R3: Partition index is address bits 10:9. Partitions whose bit is set in WIDE_MASK (default 4'b1010: partitions 1 and 3) use 64-bit accesses, and read data word 1 carries the upper word. Other partitions use 32-bit accesses, in which only word 0 is used and read data word 1 returns 0.
- R4: `cfgRegwen` is 1 out of reset and is 0 from the edge that accepts a command until the command finishes. While it is 0, writes to the address and write-data registers (select 1, 2, 3) are ignored.
- R5: `seqIdle` is 1 exactly when a new command can be accepted.
- R6: A program or digest command to a partition whose `partLocked` bit is 1 returns code 5, raises no memory request and leaves the array unchanged.
- R7: Per-partition read-lock bits (select 4, bit i for partition i) reset to 1. A written 0 clears a bit, and a written 1 never sets it again. A read command to a partition whose bit is 0 returns code 5 without a memory request.
- R8: A program that would change a stored 1 to 0 within the granule returns code 4 and does not write. A program that only adds ones succeeds with code 0.
- R9: Every accepted command raises `opDone` for exactly one cycle. For a read this is 2 cycles after acceptance with a one-cycle memory. For a successful program it is 4 cycles after acceptance, and for a lock refusal it follows at once.
- R10: A digest command programs the 64-bit write data into the last 64-bit granule of the partition addressed, at byte offset 504 within the partition.
- R11: `errCode` holds the result of the last finished command (0 for success) until the next command finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Register select: 0 command, 1 address, 2 data word 0, 3 data word 1, 4 read locks |
| cfgWdata | input | 32 | Configuration write data |
| partLocked | input | 4 | Per-partition program lock |
| memAck | input | 1 | Memory response strobe, one cycle |
| memRdata | input | 64 | Memory read data, valid with memAck |
| cfgRegwen | output | 1 | Register write enable status |
| seqIdle | output | 1 | Ready for a command |
| opDone | output | 1 | Command completion pulse |
| errCode | output | 3 | Result of last command |
| rdData0 | output | 32 | Read data word 0 |
| rdData1 | output | 32 | Read data word 1 |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Request is a program |
| memWide | output | 1 | Request is 64 bits |
| memAddr | output | 11 | Aligned byte address |
| memWdata | output | 64 | Program data |

## Verification
The hardest case to reach is a configuration write that arrives while a command is in flight. Its effect only shows later, through which word a following command touches. The bench starts a read, writes a new address one cycle later, and issues a second read without reloading the address. It then confirms that both reads return the original word. Blank-check refusals need a word that already holds ones, so the stimulus first programs a pattern, then attempts a clearing program, then a superset program. It reads back after each step.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam logic [2:0] SEL_CMD   = 3'd0;
  localparam logic [2:0] SEL_ADDR  = 3'd1;
  localparam logic [2:0] SEL_WD0   = 3'd2;
  localparam logic [2:0] SEL_WD1   = 3'd3;
  localparam logic [2:0] SEL_RLOCK = 3'd4;

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BLANK  = 3'd4;
  localparam logic [2:0] ERR_ACCESS = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_BLK, ST_WR, ST_FIN
  } seqState_e;

  typedef struct packed {
    logic cmdStart;
    logic isDigest;
    logic latchRd;
  } ctrlStrobe_t;

  typedef struct packed {
    logic wrLocked;
    logic rdLocked;
    logic blankFail;
  } dpStat_t;
endpackage

// File: rtl/dacc_ctrl.sv
module dacc_ctrl
  import dacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdWe,
  input  logic [2:0]  cmdBits,
  input  dpStat_t     stat,
  input  logic        memAck,
  output ctrlStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        seqIdle,
  output logic        opDone,
  output logic [2:0]  errCode
);
  seqState_e stateQ, stateD;
  logic [2:0] errQ, errD;

  always_comb begin
    stateD = stateQ;
    errD   = errQ;
    strb   = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (cmdWe && (|cmdBits)) begin
          strb.cmdStart = 1'b1;
          strb.isDigest = !cmdBits[0] && !cmdBits[1];
          if (cmdBits[0]) begin
            if (stat.rdLocked) begin
              stateD = ST_FIN;
              errD   = ERR_ACCESS;
            end else begin
              stateD = ST_RD;
            end
          end else if (stat.wrLocked) begin
            stateD = ST_FIN;
            errD   = ERR_ACCESS;
          end else begin
            stateD = ST_BLK;
          end
        end
      end
      ST_RD: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.latchRd = 1'b1;
          stateD = ST_FIN;
          errD   = ERR_NONE;
        end
      end
      ST_BLK: begin
        memReq = 1'b1;
        if (memAck) begin
          if (stat.blankFail) begin
            stateD = ST_FIN;
            errD   = ERR_BLANK;
          end else begin
            stateD = ST_WR;
          end
        end
      end
      ST_WR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          stateD = ST_FIN;
          errD   = ERR_NONE;
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      errQ   <= ERR_NONE;
    end else begin
      stateQ <= stateD;
      errQ   <= errD;
    end
  end

  assign seqIdle = (stateQ == ST_IDLE);
  assign opDone  = (stateQ == ST_FIN);
  assign errCode = errQ;
endmodule

// File: rtl/dacc_dp.sv
module dacc_dp
  import dacc_pkg::*;
#(
  parameter int AW = 11,
  parameter int NPART = 4,
  parameter logic [NPART-1:0] WIDE_MASK = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [31:0]      cfgWdata,
  input  logic             regwen,
  input  logic [NPART-1:0] partLocked,
  input  ctrlStrobe_t      strb,
  input  logic [63:0]      memRdata,
  output dpStat_t          stat,
  output logic             memWide,
  output logic [AW-1:0]    memAddr,
  output logic [63:0]      memWdata,
  output logic [31:0]      rdData0,
  output logic [31:0]      rdData1
);
  localparam int PW = $clog2(NPART);
  localparam int LOW = AW - PW;

  logic [AW-1:0]    addrQ;
  logic [31:0]      wd0Q, wd1Q, rd0Q, rd1Q;
  logic [NPART-1:0] rlockQ;
  logic             digestQ;
  logic [PW-1:0]    partIdx;
  logic [63:0]      rdMasked;

  assign partIdx = addrQ[AW-1 -: PW];
  assign memWide = WIDE_MASK[partIdx] | digestQ;

  always_comb begin
    if (digestQ)      memAddr = {partIdx, {(LOW-3){1'b1}}, 3'b000};
    else if (memWide) memAddr = {addrQ[AW-1:3], 3'b000};
    else              memAddr = {addrQ[AW-1:2], 2'b00};
  end

  assign memWdata = memWide ? {wd1Q, wd0Q} : {32'd0, wd0Q};
  assign rdMasked = memWide ? memRdata : {32'd0, memRdata[31:0]};

  assign stat.wrLocked  = partLocked[partIdx];
  assign stat.rdLocked  = !rlockQ[partIdx];
  assign stat.blankFail = |(rdMasked & ~memWdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ   <= '0;
      wd0Q    <= '0;
      wd1Q    <= '0;
      rd0Q    <= '0;
      rd1Q    <= '0;
      rlockQ  <= '1;
      digestQ <= 1'b0;
    end else begin
      if (cfgWe && regwen) begin
        if (cfgSel == SEL_ADDR) addrQ <= cfgWdata[AW-1:0];
        if (cfgSel == SEL_WD0)  wd0Q  <= cfgWdata;
        if (cfgSel == SEL_WD1)  wd1Q  <= cfgWdata;
      end
      if (cfgWe && cfgSel == SEL_RLOCK) rlockQ <= rlockQ & cfgWdata[NPART-1:0];
      if (strb.cmdStart) digestQ <= strb.isDigest;
      if (strb.latchRd) begin
        rd0Q <= rdMasked[31:0];
        rd1Q <= rdMasked[63:32];
      end
    end
  end

  assign rdData0 = rd0Q;
  assign rdData1 = rd1Q;
endmodule

// File: rtl/direct_access_seq.sv
module direct_access_seq
  import dacc_pkg::*;
#(
  parameter int AW = 11,
  parameter int NPART = 4,
  parameter logic [NPART-1:0] WIDE_MASK = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [2:0]       cfgSel,
  input  logic [31:0]      cfgWdata,
  input  logic [NPART-1:0] partLocked,
  input  logic             memAck,
  input  logic [63:0]      memRdata,
  output logic             cfgRegwen,
  output logic             seqIdle,
  output logic             opDone,
  output logic [2:0]       errCode,
  output logic [31:0]      rdData0,
  output logic [31:0]      rdData1,
  output logic             memReq,
  output logic             memWe,
  output logic             memWide,
  output logic [AW-1:0]    memAddr,
  output logic [63:0]      memWdata
);
  ctrlStrobe_t strb;
  dpStat_t     stat;

  dacc_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cmdWe(cfgWe && cfgSel == SEL_CMD), .cmdBits(cfgWdata[2:0]),
    .stat(stat), .memAck(memAck), .strb(strb),
    .memReq(memReq), .memWe(memWe), .seqIdle(seqIdle),
    .opDone(opDone), .errCode(errCode)
  );

  dacc_dp #(.AW(AW), .NPART(NPART), .WIDE_MASK(WIDE_MASK)) dp_i (
    .clk(clk), .rst_n(rst_n),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .regwen(seqIdle), .partLocked(partLocked), .strb(strb),
    .memRdata(memRdata), .stat(stat), .memWide(memWide),
    .memAddr(memAddr), .memWdata(memWdata),
    .rdData0(rdData0), .rdData1(rdData1)
  );

  assign cfgRegwen = seqIdle;
endmodule

// File: rtl/direct_access_seq_chk.sv
module direct_access_seq_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfgRegwen,
  input logic          seqIdle,
  input logic          opDone,
  input logic [2:0]    errCode,
  input logic          memReq,
  input logic          memWide,
  input logic [AW-1:0] memAddr
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> !opDone); // R9
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |=> seqIdle); // R5
  AST_REQ_NO_REGWEN: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> !cfgRegwen); // R4
  AST_ALIGN_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |-> memAddr[1:0] == 2'b00); // R2
  AST_ALIGN_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWide) |-> memAddr[2] == 1'b0); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && $past(memReq)) |-> $stable(memAddr)); // R4
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    opDone |-> (errCode == 3'd0 || errCode == 3'd4 || errCode == 3'd5)); // R11
endmodule

bind direct_access_seq direct_access_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfgRegwen(cfgRegwen), .seqIdle(seqIdle),
  .opDone(opDone), .errCode(errCode), .memReq(memReq),
  .memWide(memWide), .memAddr(memAddr)
);

// File: tb/direct_access_seq_tb_top.sv
`timescale 1ns/1ps
module direct_access_seq_tb_top;
  localparam logic [3:0] WIDE = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWe = 1'b0;
  logic [2:0] cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [3:0] partLocked = '0;
  logic memAck;
  logic [63:0] memRdata;
  logic cfgRegwen, seqIdle, opDone, memReq, memWe, memWide;
  logic [2:0] errCode;
  logic [31:0] rdData0, rdData1;
  logic [10:0] memAddr;
  logic [63:0] memWdata;

  always #10 clk = ~clk;

  direct_access_seq dut_i (.*);

  logic [31:0] bmem [0:511];
  logic [31:0] mMem [0:511];
  logic [10:0] mAddr;
  logic [31:0] mWd0, mWd1, mRd0, mRd1;
  logic [3:0]  mRlock;
  logic [2:0]  mErr;
  int nChk = 0;
  int nFail = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= memReq && !memAck;
      if (memReq && !memAck) begin
        if (memWe) begin
          bmem[memAddr[10:2]] <= memWdata[31:0];
          if (memWide) bmem[memAddr[10:2] + 9'd1] <= memWdata[63:32];
        end
        memRdata <= {memWide ? bmem[memAddr[10:2] + 9'd1] : 32'd0, bmem[memAddr[10:2]]};
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      3'd1: mAddr = data[10:0];
      3'd2: mWd0 = data;
      3'd3: mWd1 = data;
      3'd4: mRlock = mRlock & data[3:0];
      default: ;
    endcase
  endtask

  task automatic runCmd(input logic [2:0] cmd, input string req);
    int p, idx, dly;
    bit wide;
    logic [63:0] oldV, newV;
    p = int'(mAddr[10:9]);
    wide = WIDE[p];
    if (cmd[0]) begin
      if (!mRlock[p]) begin mErr = 3'd5; dly = 0; end
      else begin
        mErr = 3'd0; dly = 2;
        idx = wide ? int'(mAddr[10:3]) * 2 : int'(mAddr[10:2]);
        mRd0 = mMem[idx];
        mRd1 = wide ? mMem[idx+1] : 32'd0;
      end
    end else begin
      if (cmd[2] && !cmd[1]) begin
        wide = 1'b1;
        idx = (p * 512 + 504) / 4;
      end else begin
        idx = wide ? int'(mAddr[10:3]) * 2 : int'(mAddr[10:2]);
      end
      if (partLocked[p]) begin mErr = 3'd5; dly = 0; end
      else begin
        oldV = {wide ? mMem[idx+1] : 32'd0, mMem[idx]};
        newV = {wide ? mWd1 : 32'd0, mWd0};
        if ((oldV & ~newV) != 64'd0) begin mErr = 3'd4; dly = 2; end
        else begin
          mErr = 3'd0; dly = 4;
          mMem[idx] = mWd0;
          if (wide) mMem[idx+1] = mWd1;
        end
      end
    end
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 3'd0; cfgWdata = {29'd0, cmd};
    @(negedge clk);
    cfgWe = 1'b0;
    for (int k = 0; k <= dly + 1; k++) begin
      chk(opDone == (k == dly), "R9", $sformatf("%s opDone k=%0d", req, k), 64'(opDone), 64'(k == dly));
      chk(seqIdle == (k > dly), "R5", $sformatf("%s idle k=%0d", req, k), 64'(seqIdle), 64'(k > dly));
      if (k <= dly)
        chk(cfgRegwen == 1'b0, "R4", $sformatf("%s regwen k=%0d", req, k), 64'(cfgRegwen), 64'd0);
      if (mErr == 3'd5)
        chk(memReq == 1'b0, req, "no memory request on lock", 64'(memReq), 64'd0);
      if (k <= dly) @(negedge clk);
    end
    chk(errCode == mErr, "R11", $sformatf("%s code", req), 64'(errCode), 64'(mErr));
    chk(rdData0 == mRd0, req, "rdData0", 64'(rdData0), 64'(mRd0));
    chk(rdData1 == mRd1, req, "rdData1", 64'(rdData1), 64'(mRd1));
  endtask

  initial begin
    #2000000;
    nFail++; nChk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) begin bmem[i] = '0; mMem[i] = '0; end
    mAddr = '0; mWd0 = '0; mWd1 = '0; mRd0 = '0; mRd1 = '0; mRlock = 4'hF; mErr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seqIdle == 1'b1, "R5", "reset idle", 64'(seqIdle), 64'd1);
    chk(cfgRegwen == 1'b1, "R4", "reset regwen", 64'(cfgRegwen), 64'd1);
    chk(errCode == 3'd0 && opDone == 1'b0, "R11", "reset code/done", 64'(errCode), 64'd0);

    // R3 narrow partition program, R2 misaligned readback
    cfgWrite(3'd1, 32'h010); cfgWrite(3'd2, 32'h0000_00F0);
    runCmd(3'b010, "R3 narrow program");
    cfgWrite(3'd1, 32'h013);
    runCmd(3'b001, "R2 narrow misaligned read");
    // R3 wide partition, R2 misaligned wide read
    cfgWrite(3'd1, 32'h208); cfgWrite(3'd2, 32'h9ABC_DEF0); cfgWrite(3'd3, 32'h1234_5678);
    runCmd(3'b010, "R3 wide program");
    cfgWrite(3'd1, 32'h20F);
    runCmd(3'b001, "R2 wide misaligned read");
    // R8 blank check
    cfgWrite(3'd1, 32'h010); cfgWrite(3'd2, 32'h0000_000F);
    runCmd(3'b010, "R8 clearing program");
    runCmd(3'b001, "R8 readback after refusal");
    cfgWrite(3'd2, 32'h0000_00FF);
    runCmd(3'b010, "R8 superset program");
    runCmd(3'b001, "R8 readback superset");
    // R1 priority
    cfgWrite(3'd1, 32'h020); cfgWrite(3'd2, 32'h0000_0055);
    runCmd(3'b111, "R1 multi-bit command");
    runCmd(3'b001, "R1 array untouched");
    // R4 address write during busy ignored
    cfgWrite(3'd1, 32'h010);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 3'd0; cfgWdata = 32'd1;
    @(negedge clk);
    cfgSel = 3'd1; cfgWdata = 32'h020;
    chk(cfgRegwen == 1'b0, "R4", "regwen low while busy", 64'(cfgRegwen), 64'd0);
    @(negedge clk);
    cfgWe = 1'b0;
    repeat (4) @(negedge clk);
    chk(seqIdle == 1'b1 && rdData0 == 32'hFF, "R4", "read during busy write", 64'(rdData0), 64'hFF);
    mRd0 = 32'hFF; mRd1 = 32'd0;
    runCmd(3'b001, "R4 address kept");
    // R6 program lock
    partLocked = 4'b0100;
    cfgWrite(3'd1, 32'h410); cfgWrite(3'd2, 32'h0000_0001);
    runCmd(3'b010, "R6 locked program");
    runCmd(3'b100, "R6 locked digest");
    partLocked = 4'b0000;
    runCmd(3'b001, "R6 array untouched");
    // R10 digest
    cfgWrite(3'd1, 32'h600); cfgWrite(3'd2, 32'h0000_BEEF); cfgWrite(3'd3, 32'hDEAD_0000);
    runCmd(3'b100, "R10 digest");
    cfgWrite(3'd1, 32'h7F8);
    runCmd(3'b001, "R10 digest readback");
    // R7 read lock
    cfgWrite(3'd4, 32'h0000_000E);
    cfgWrite(3'd1, 32'h010);
    runCmd(3'b001, "R7 read locked");
    cfgWrite(3'd4, 32'h0000_000F);
    runCmd(3'b001, "R7 lock stays after writing 1");
    cfgWrite(3'd1, 32'h208);
    runCmd(3'b001, "R7 other partition readable");

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule